// File: doc/BRIEF.md
# Oscillator Auto-Trim Supervisor

This block runs and polices a closed trim loop for an on-chip 48 MHz RC oscillator. The oscillator is also the block's own clock, so the block counts its clock cycles across a window made of a fixed number of reference-clock periods. After each window it compares that count with a target. If the count is within a tolerance, the block reports lock. Otherwise it steps a trim code one position toward the target. The window boundary is produced in the reference domain as a toggle. It crosses into the oscillator domain through a two-flop synchroniser, so successive boundaries keep their exact spacing.

On top of the loop the block adds supervision. A retry budget caps the number of trim-code updates. A plausibility range on the count catches a clock that is far off. An optional check flags any attempt to push the trim code past its limits. When the loop gives up it clears its own mode select. A budget exhaustion always stops it, and a clock error stops it only when software asks for that. Software sees a control word and a status word, clears flags by writing ones, and receives one interrupt line.

Top module: `osc_trim_supervisor`

## Requirements
- R1: The status word carries lock at bit 0, trim failure at bit 1, clock error at bit 2 and over-boundary at bit 3, with bits 31:4 reading zero. Reset clears both words and the interrupt and loads the trim code with TRIM_INIT.
- R2: The failure, clock-error and over-boundary flags are sticky. A status write (wr_addr=1) with a 1 in a flag's position clears that flag, and a 0 leaves it alone. A hardware set in the same cycle as the clear keeps the flag set. Writes never change the lock bit.
- R3: Each evaluated window that is neither locked nor a clock error consumes one update and steps the trim code by one: up when the count is below TARGET, down when it is above. When RETRY_MAX updates have been used and a further window is unlocked, the failure flag sets and the mode select is forced to 00 unconditionally.
- R4: A window count below CE_LO or above CE_HI (both bounds themselves are plausible) sets the clock-error flag. Such a window neither steps the code nor consumes an update.
- R5: A clock error forces the mode select to 00 only when control bit 8 (clock-error stop) is 1. Otherwise the loop keeps running.
- R6: The interrupt output is high exactly when (failure flag AND control bit 12) OR (clock-error flag AND control bit 13).
- R7: A window count within TARGET±TOL inclusive sets the lock bit and leaves the code unchanged. Lock never raises the interrupt.
- R8: The lock bit is 0 whenever the mode select is 00.
- R9: When a step would take the code outside [TRIM_MIN, TRIM_MAX], the code is held and the update is still consumed. The over-boundary flag then sets only if control bit 4 is 1.
- R10: A control write (wr_addr=0) with a nonzero mode select restarts the loop. It reloads the code with TRIM_INIT, zeroes the update count and discards the first window that ends after the restart.
- R11: The control word holds mode at bits 1:0 (any nonzero value runs the loop), the boundary check enable at bit 4, the clock-error stop at bit 8, the failure interrupt enable at bit 12 and the clock-error interrupt enable at bit 13. All other bits read zero. A window spans WIN_REF reference rising edges, and its count is the number of clk cycles between successive synchronised window boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, also the system clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ref_clk | input | 1 | Reference clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 the status word |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Control word readback |
| status_q | output | 32 | Status word readback |
| trim_code | output | TRIM_W | Trim code driven to the oscillator |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the reference period so that the window count passes through every interesting point. These are the two plausibility bounds and the values just outside them, the edges of the lock tolerance and the values just outside those, and runs up and down into both trim limits. A design that is off by one at a bound would report a clock error, or miss one, on a bound count. A design with the tolerance edges wrong would step the code when it should lock. Counting the boundary attempt wrongly shows up as a wrong final code or a missing failure.

Control settings vary with the sweep. A design that stops on a clock error without the stop enable would leave a mode select of 00 where the bench expects it kept. A design that routes lock into the interrupt would raise the line in a locked run. Sticky-flag tests catch a clear that also wipes neighbouring flags, a write of 0 that clears a flag, and a lock bit that writes can alter.

// File: rtl/osc_trim_supervisor.sv
`timescale 1ns/1ps
module osc_trim_supervisor #(
  parameter int TRIM_W    = 6,
  parameter int TRIM_INIT = 32,
  parameter int TRIM_MIN  = 0,
  parameter int TRIM_MAX  = 63,
  parameter int WIN_REF   = 8,
  parameter int TARGET    = 384,
  parameter int TOL       = 4,
  parameter int CE_LO     = 192,
  parameter int CE_HI     = 768,
  parameter int RETRY_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       status_q,
  output logic [TRIM_W-1:0] trim_code,
  output logic              irq
);
  localparam int REF_CW = (WIN_REF > 1) ? $clog2(WIN_REF) : 1;
  localparam int CNT_W  = $clog2(CE_HI + 2) + 1;
  localparam int MW     = CNT_W + 1;
  localparam int RTY_W  = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;
  localparam logic [REF_CW-1:0] REF_LAST = REF_CW'(WIN_REF - 1);
  localparam logic [MW-1:0]     M_LO  = MW'(CE_LO);
  localparam logic [MW-1:0]     M_HI  = MW'(CE_HI);
  localparam logic [MW-1:0]     M_TGT = MW'(TARGET);
  localparam logic [MW-1:0]     M_LKL = MW'(TARGET - TOL);
  localparam logic [MW-1:0]     M_LKH = MW'(TARGET + TOL);
  localparam logic [TRIM_W-1:0] C_INIT = TRIM_W'(TRIM_INIT);
  localparam logic [TRIM_W-1:0] C_MIN  = TRIM_W'(TRIM_MIN);
  localparam logic [TRIM_W-1:0] C_MAX  = TRIM_W'(TRIM_MAX);
  localparam logic [RTY_W-1:0]  R_MAX  = RTY_W'(RETRY_MAX);

  logic [REF_CW-1:0] ref_cnt;
  logic              ref_tgl;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_tgl <= 1'b0;
    end else if (ref_cnt == REF_LAST) begin
      ref_cnt <= '0;
      ref_tgl <= ~ref_tgl;
    end else
      ref_cnt <= ref_cnt + 1'b1;

  logic [2:0] sync_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_tgl};
  wire tick = sync_q[2] ^ sync_q[1];

  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= '0;
    else if (tick)           cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;

  logic [MW-1:0] meas;
  assign meas = {1'b0, cnt_q} + 1'b1;

  logic [1:0]        mode_q;
  logic              bnd_en_q, cestop_q, ie_fail_q, ie_cerr_q;
  logic              lock_q, fail_q, cerr_q, ob_q, primed_q;
  logic [TRIM_W-1:0] code_q;
  logic [RTY_W-1:0]  upd_q;

  wire wr_ctrl  = wr_en && !wr_addr;
  wire wr_stat  = wr_en &&  wr_addr;
  wire restart  = wr_ctrl && (wr_data[1:0] != 2'b00);
  wire idle_wr  = wr_ctrl && (wr_data[1:0] == 2'b00);
  wire active   = mode_q != 2'b00;
  wire eval     = tick && active && primed_q && !restart;
  wire is_cerr  = (meas < M_LO) || (meas > M_HI);
  wire in_lock  = (meas >= M_LKL) && (meas <= M_LKH);
  wire go_up    = meas < M_TGT;
  wire at_bound = go_up ? (code_q == C_MAX) : (code_q == C_MIN);
  wire spent    = upd_q == R_MAX;
  wire ev_cerr  = eval && is_cerr;
  wire ev_lock  = eval && !is_cerr && in_lock;
  wire ev_miss  = eval && !is_cerr && !in_lock;
  wire ev_fail  = ev_miss && spent;
  wire ev_step  = ev_miss && !spent;
  wire ev_ob    = ev_step && at_bound && bnd_en_q;
  wire hw_stop  = ev_fail || (ev_cerr && cestop_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q    <= 2'b00;
      bnd_en_q  <= 1'b0;
      cestop_q  <= 1'b0;
      ie_fail_q <= 1'b0;
      ie_cerr_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q    <= wr_data[1:0];
        bnd_en_q  <= wr_data[4];
        cestop_q  <= wr_data[8];
        ie_fail_q <= wr_data[12];
        ie_cerr_q <= wr_data[13];
      end
      if (hw_stop) mode_q <= 2'b00;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      code_q   <= C_INIT;
      upd_q    <= '0;
      primed_q <= 1'b0;
      lock_q   <= 1'b0;
    end else if (restart) begin
      code_q   <= C_INIT;
      upd_q    <= '0;
      primed_q <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (tick && active) primed_q <= 1'b1;
      if (ev_lock)                  lock_q <= 1'b1;
      else if (ev_miss || ev_cerr)  lock_q <= 1'b0;
      if (ev_step) begin
        upd_q <= upd_q + 1'b1;
        if (!at_bound) code_q <= go_up ? code_q + 1'b1 : code_q - 1'b1;
      end
      if (hw_stop || idle_wr) lock_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fail_q <= 1'b0;
      cerr_q <= 1'b0;
      ob_q   <= 1'b0;
    end else begin
      if (wr_stat && wr_data[1]) fail_q <= 1'b0;
      if (wr_stat && wr_data[2]) cerr_q <= 1'b0;
      if (wr_stat && wr_data[3]) ob_q   <= 1'b0;
      if (ev_fail) fail_q <= 1'b1;
      if (ev_cerr) cerr_q <= 1'b1;
      if (ev_ob)   ob_q   <= 1'b1;
    end

  assign status_q  = {28'b0, ob_q, cerr_q, fail_q, lock_q};
  assign ctrl_q    = {18'b0, ie_cerr_q, ie_fail_q, 3'b0, cestop_q, 3'b0,
                      bnd_en_q, 2'b0, mode_q};
  assign trim_code = code_q;
  assign irq       = (fail_q && ie_fail_q) || (cerr_q && ie_cerr_q);

  logic unused_wr;
  assign unused_wr = ^{wr_data[31:14], wr_data[11:9], wr_data[7:5], wr_data[0]};
endmodule

// File: rtl/trim_sup_chk.sv
`timescale 1ns/1ps
module trim_sup_chk #(
  parameter int TRIM_W   = 6,
  parameter int TRIM_MIN = 0,
  parameter int TRIM_MAX = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [3:0]        wr_lo,
  input logic [1:0]        mode,
  input logic              cestop,
  input logic [31:0]       status_q,
  input logic [TRIM_W-1:0] trim_code,
  input logic              irq
);
  localparam logic [TRIM_W-1:0] C_MIN = TRIM_W'(TRIM_MIN);
  localparam logic [TRIM_W-1:0] C_MAX = TRIM_W'(TRIM_MAX);

  logic rs, clr_fail, clr_ob;
  assign rs       = wr_en && !wr_addr && (wr_lo[1:0] != 2'b00);
  assign clr_fail = wr_en && wr_addr && wr_lo[1];
  assign clr_ob   = wr_en && wr_addr && wr_lo[3];

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[31:4] == 28'b0);

  a_r2_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q[1]) && !$past(clr_fail)) |-> status_q[1]);

  a_r2_ob_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q[3]) && !$past(clr_ob)) |-> status_q[3]);

  a_r3_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[1]) |-> (mode == 2'b00));

  a_r5_cerr_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q[2]) && $past(cestop)) |-> (mode == 2'b00));

  a_r7_lock_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[2:1] == 2'b00) |-> !irq);

  a_r8_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !status_q[0]);

  a_r9_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_code >= C_MIN) && (trim_code <= C_MAX));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rs) |-> ((trim_code == $past(trim_code)) ||
                    (trim_code == $past(trim_code) + 1'b1) ||
                    (trim_code == $past(trim_code) - 1'b1)));
endmodule

bind osc_trim_supervisor trim_sup_chk #(
  .TRIM_W(TRIM_W), .TRIM_MIN(TRIM_MIN), .TRIM_MAX(TRIM_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_lo(wr_data[3:0]), .mode(ctrl_q[1:0]), .cestop(ctrl_q[8]),
  .status_q(status_q), .trim_code(trim_code), .irq(irq)
);

// File: tb/test_osc_trim_supervisor.sv
`timescale 1ns/1ps
module test_osc_trim_supervisor;
  localparam int TW = 3, INIT = 3, CMIN = 1, CMAX = 5, WREF = 2;
  localparam int TGT = 48, TL = 2, LO = 20, HI = 80, RMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_q, status_q;
  logic [TW-1:0] trim_code;
  logic irq;
  int ref_per = 24, hc = 0;
  int n_chk = 0, n_bad = 0;

  osc_trim_supervisor #(.TRIM_W(TW), .TRIM_INIT(INIT), .TRIM_MIN(CMIN),
    .TRIM_MAX(CMAX), .WIN_REF(WREF), .TARGET(TGT), .TOL(TL), .CE_LO(LO),
    .CE_HI(HI), .RETRY_MAX(RMAX)) i_osc_trim_supervisor (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .status_q(status_q), .trim_code(trim_code), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    hc = hc + 1;
    if (ref_clk && hc >= ref_per / 2) begin ref_clk = 1'b0; hc = 0; end
    else if (!ref_clk && hc >= ref_per - ref_per / 2) begin ref_clk = 1'b1; hc = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset status", status_q, 32'h0);
    chk("R1 reset ctrl", ctrl_q, 32'h0);
    chk("R1 reset code", 32'(trim_code), 32'(INIT));
    chk("R1 reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    wr(1'b0, 32'hFFFF_FFFF);
    chk("R11 ctrl layout", ctrl_q, 32'h0000_3113);
    wr(1'b0, 32'h0);

    for (int s = 8; s <= 44; s++) begin
      int p, code, mexp, ob, fl, ce, lk;
      logic [31:0] cfg;
      logic bnd, cst, ief, iec, up;
      bnd = (s % 2) == 1; cst = ((s / 2) % 2) == 1;
      ief = ((s / 3) % 2) == 1; iec = ((s / 5) % 2) == 0;
      cfg = 32'((s % 3) + 1) | (bnd ? 32'h10 : 0) | (cst ? 32'h100 : 0) |
            (ief ? 32'h1000 : 0) | (iec ? 32'h2000 : 0);
      wr(1'b0, 32'h0);
      wr(1'b1, 32'hFFFF_FFFF);
      ref_per = s;
      repeat (300) @(negedge clk);
      wr(1'b0, cfg);
      repeat (1000) @(negedge clk);

      p = WREF * s; code = INIT; ob = 0; fl = 0; ce = 0; lk = 0;
      mexp = int'(cfg);
      if (p < LO || p > HI) begin
        ce = 1;
        if (cst) mexp = mexp & ~3;
      end else if (p >= TGT - TL && p <= TGT + TL) begin
        lk = 1;
      end else begin
        up = p < TGT;
        for (int k = 0; k < RMAX; k++) begin
          if (up) begin if (code == CMAX) ob = ob | int'(bnd); else code++; end
          else    begin if (code == CMIN) ob = ob | int'(bnd); else code--; end
        end
        fl = 1; mexp = mexp & ~3;
      end
      chk($sformatf("R3/R4/R7/R9/R11 code s=%0d", s), 32'(trim_code), 32'(code));
      chk($sformatf("R1/R3/R4/R7/R9 status s=%0d", s), status_q,
          32'(ob * 8 + ce * 4 + fl * 2 + lk));
      chk($sformatf("R3/R5 mode s=%0d", s), ctrl_q, 32'(mexp));
      chk($sformatf("R6 irq s=%0d", s), 32'(irq),
          32'((fl & int'(ief)) | (ce & int'(iec))));
      if (lk == 1) begin
        wr(1'b1, 32'hF);
        chk($sformatf("R2 lock unwritable s=%0d", s), status_q, 32'h1);
        wr(1'b0, 32'h0);
        chk($sformatf("R8 lock cleared idle s=%0d", s), status_q, 32'h0);
      end
    end

    wr(1'b0, 32'h0);
    wr(1'b1, 32'hF);
    ref_per = 14;
    repeat (300) @(negedge clk);
    wr(1'b0, 32'h0000_1011);
    repeat (1000) @(negedge clk);
    chk("R9 bound flagged", status_q, 32'hA);
    chk("R6 irq on failure", 32'(irq), 32'h1);
    wr(1'b1, 32'h0);
    chk("R2 zero write keeps flags", status_q, 32'hA);
    wr(1'b1, 32'h2);
    chk("R2 clear failure only", status_q, 32'h8);
    chk("R6 irq drops on clear", 32'(irq), 32'h0);
    wr(1'b1, 32'h8);
    chk("R2 clear bound flag", status_q, 32'h0);
    chk("R10 code held after stop", 32'(trim_code), 32'(CMAX));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule